// File: doc/BRIEF.md
# DMA Master Control and Status Register

This block is the global control and status register of a multi-channel DMA controller. It keeps one read/write master enable and two sticky error flags: one raised by the transfer logic when it reports an address error, and one raised by a non-maskable interrupt. From these three bits and each channel's own enable and transfer-end inputs it produces a registered per-channel transfer permission. It also produces an abort request that tells the transfer engine to abandon a unit in progress.

Software clears an error flag only in two steps. First a read must return the flag as 1, then a write must put 0 into that bit. A flag that sets in the same cycle as a clearing write stays set. When the non-maskable interrupt arrives while a transfer unit is in flight, the channels that were running keep their permission until that unit completes, and then all channels stop. When the master enable is cleared, or an address error occurs, while a unit is busy, the permission drops at once and the abort request is raised.

Top module: `dma_master_ctl`

## Requirements
- R1: After `rst_n` is released, and in the cycle after `soft_rst` is high, `rd_data` reads 0 and `ch_permit` and `abort_req` are 0.
- R2: Bit 0 of the register is the master enable and follows bit 0 of every write. Bit 1 is the NMI flag and bit 2 is the address-error flag. Writing 1 to either flag bit has no effect. Bits 3 and up read 0 and ignore writes.
- R3: An `addr_err` pulse sets the address-error flag, and `rd_data` bit 2 shows it from the next clock edge.
- R4: An `nmi` pulse sets the NMI flag, and `rd_data` bit 1 shows it from the next clock edge, whether or not `unit_busy` is high.
- R5: A write with 0 in a flag bit clears that flag only if, since the previous write, a read (`reg_sel`=1, `reg_wr`=0) returned that same flag as 1. The read-1 record is kept separately for each flag, and any write discards it.
- R6: If a flag's setting pulse and a valid clearing write occur in the same cycle, the flag stays 1.
- R7: From the clock edge after the inputs are applied, `ch_permit[i]` is 1 exactly when the master enable is 1, `ch_en[i]` is 1, `ch_te[i]` is 0, and both flags are 0.
- R8: If `nmi` pulses while `unit_busy` is 1, each channel that was permitted stays permitted, provided its other conditions still hold, for as long as `unit_busy` stays 1. Its permission drops at the edge where `unit_busy` is sampled 0.
- R9: `abort_req` is 1 from the edge after a cycle in which `unit_busy` is 1 and either the master enable is 0 or a flag is set, except during the NMI completion window of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously |
| soft_rst | input | 1 | Synchronous manual reset, active high |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write access, 0 = read access |
| reg_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Register contents |
| addr_err | input | 1 | Address-error pulse from the transfer logic |
| nmi | input | 1 | Non-maskable interrupt pulse |
| unit_busy | input | 1 | A transfer unit is in flight |
| ch_en | input | NUM_CH | Per-channel enable |
| ch_te | input | NUM_CH | Per-channel transfer-end flag |
| ch_permit | output | NUM_CH | Per-channel transfer permission |
| abort_req | output | 1 | Abandon the unit in progress |

## Verification
A stuck or stray read-1 record shows at the ports in the write right after it. A flag then either clears without a prior read, or stays set after a proper handshake, and `rd_data` shows this one edge after that write. A wrong completion-window state shows as `ch_permit` staying high or dropping one cycle early around the fall of `unit_busy`, together with a wrong `abort_req` at the same edge. The bench checks every cycle it drives, so any such error is reported within one clock of its cause.

// File: rtl/dma_mc_pkg.sv
package dma_mc_pkg;
  localparam int unsigned BIT_ME   = 0;
  localparam int unsigned BIT_NMI  = 1;
  localparam int unsigned BIT_AE   = 2;
  localparam int unsigned CTL_BITS = 3;
endpackage

// File: rtl/dma_mc_rstsync.sv
module dma_mc_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dma_mc_flag.sv
module dma_mc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic set_i,
  input  logic rd_acc,
  input  logic wr_acc,
  input  logic wbit,
  output logic flag_q,
  output logic flag_nx
);
  logic rd1_q, rd1_d;
  logic clr_ok;

  always_comb begin
    clr_ok = wr_acc & ~wbit & rd1_q;
    if (soft_rst)             rd1_d = 1'b0;
    else if (wr_acc)          rd1_d = 1'b0;
    else if (rd_acc & flag_q) rd1_d = 1'b1;
    else                      rd1_d = rd1_q;
    if (soft_rst) flag_nx = 1'b0;
    else          flag_nx = set_i | (flag_q & ~clr_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      rd1_q  <= 1'b0;
    end else begin
      flag_q <= flag_nx;
      rd1_q  <= rd1_d;
    end
  end

  AST_FLAG_FALL_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flag_q) && !$past(soft_rst)) |-> $past(rd1_q && wr_acc && !wbit)); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !soft_rst) |=> flag_q); // R6
  AST_RD1_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && flag_q && !soft_rst) |=> rd1_q); // R5
endmodule

// File: rtl/dma_mc_gate.sv
module dma_mc_gate #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              me_nx,
  input  logic              ae_nx,
  input  logic              nmi_nx,
  input  logic              nmi,
  input  logic              unit_busy,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_te,
  output logic [NUM_CH-1:0] ch_permit,
  output logic              abort_req
);
  logic              drain_q, drain_d;
  logic              abort_d;
  logic [NUM_CH-1:0] permit_d;
  logic              base_ok;
  logic              keep_ok;

  always_comb begin
    drain_d = ~soft_rst & unit_busy & (nmi | drain_q);
    base_ok = me_nx & ~ae_nx & ~nmi_nx;
    keep_ok = drain_d & me_nx & ~ae_nx;
    abort_d = ~soft_rst & unit_busy & ~drain_d & (~me_nx | ae_nx | nmi_nx);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic ch_ok;
    always_comb begin
      ch_ok       = ch_en[c] & ~ch_te[c];
      permit_d[c] = ~soft_rst & ch_ok & (base_ok | (keep_ok & ch_permit[c]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_q   <= 1'b0;
      ch_permit <= '0;
      abort_req <= 1'b0;
    end else begin
      drain_q   <= drain_d;
      ch_permit <= permit_d;
      abort_req <= abort_d;
    end
  end

  AST_PERMIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_permit & ~$past(ch_en)) == '0); // R7
  AST_PERMIT_NOT_TE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_permit & $past(ch_te)) == '0); // R7
  AST_DRAIN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_busy |=> !drain_q); // R8
  AST_NO_ABORT_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    drain_q |-> !abort_req); // R9
endmodule

// File: rtl/dma_master_ctl.sv
module dma_master_ctl #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              addr_err,
  input  logic              nmi,
  input  logic              unit_busy,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_te,
  output logic [NUM_CH-1:0] ch_permit,
  output logic              abort_req
);
  import dma_mc_pkg::*;

  logic rst_sync_n;
  logic rd_acc, wr_acc;
  logic me_q, me_nx;
  logic ae_q, ae_nx;
  logic nmif_q, nmif_nx;
  logic [DATA_W-1:0] unused_wdata;

  assign unused_wdata = reg_wdata;

  dma_mc_rstsync #(.STAGES(2)) i_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    rd_acc = reg_sel & ~reg_wr;
    wr_acc = reg_sel & reg_wr;
    if (soft_rst)    me_nx = 1'b0;
    else if (wr_acc) me_nx = reg_wdata[BIT_ME];
    else             me_nx = me_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) me_q <= 1'b0;
    else             me_q <= me_nx;
  end

  dma_mc_flag i_flag_ae (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .soft_rst (soft_rst),
    .set_i    (addr_err),
    .rd_acc   (rd_acc),
    .wr_acc   (wr_acc),
    .wbit     (reg_wdata[BIT_AE]),
    .flag_q   (ae_q),
    .flag_nx  (ae_nx)
  );

  dma_mc_flag i_flag_nmi (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .soft_rst (soft_rst),
    .set_i    (nmi),
    .rd_acc   (rd_acc),
    .wr_acc   (wr_acc),
    .wbit     (reg_wdata[BIT_NMI]),
    .flag_q   (nmif_q),
    .flag_nx  (nmif_nx)
  );

  dma_mc_gate #(.NUM_CH(NUM_CH)) i_gate (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .soft_rst  (soft_rst),
    .me_nx     (me_nx),
    .ae_nx     (ae_nx),
    .nmi_nx    (nmif_nx),
    .nmi       (nmi),
    .unit_busy (unit_busy),
    .ch_en     (ch_en),
    .ch_te     (ch_te),
    .ch_permit (ch_permit),
    .abort_req (abort_req)
  );

  always_comb begin
    rd_data          = '0;
    rd_data[BIT_ME]  = me_q;
    rd_data[BIT_NMI] = nmif_q;
    rd_data[BIT_AE]  = ae_q;
  end

  AST_PERMIT_NEEDS_ME: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|ch_permit) |-> me_q); // R7
  AST_AE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ae_q |-> (ch_permit == '0)); // R7
  AST_AE_SETS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr_err && !soft_rst) |=> ae_q); // R3
  AST_NMI_SETS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (nmi && !soft_rst) |=> nmif_q); // R4
  AST_SOFT_RST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    soft_rst |=> (!me_q && !ae_q && !nmif_q && ch_permit == '0)); // R1
  AST_ME_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_acc && !soft_rst) |=> (me_q == $past(reg_wdata[BIT_ME]))); // R2
endmodule

// File: tb/test_dma_master_ctl.sv
module test_dma_master_ctl;
  localparam int NCH = 4;
  localparam int DW  = 32;
  localparam int OW  = DW + NCH + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, reg_sel = 1'b0, reg_wr = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic addr_err = 1'b0, nmi = 1'b0, unit_busy = 1'b0;
  logic [NCH-1:0] ch_en = '0, ch_te = '0;
  logic [DW-1:0] rd_data;
  logic [NCH-1:0] ch_permit;
  logic abort_req;

  always #10 clk = ~clk;

  dma_master_ctl #(.NUM_CH(NCH), .DATA_W(DW)) i_dma_master_ctl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .rd_data(rd_data), .addr_err(addr_err), .nmi(nmi),
    .unit_busy(unit_busy), .ch_en(ch_en), .ch_te(ch_te),
    .ch_permit(ch_permit), .abort_req(abort_req)
  );

  typedef struct { logic [OW-1:0] exp; string tag; } item_t;
  item_t sbq[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic s_sel, s_wr, s_ae, s_nmi, s_srst, s_busy;
  logic [DW-1:0] s_wd;
  logic [NCH-1:0] s_en, s_te;

  function automatic logic [OW-1:0] mk(logic ab, logic [NCH-1:0] pm, logic [2:0] rd);
    return {ab, pm, {(DW-3){1'b0}}, rd};
  endfunction

  task automatic tick(input logic [OW-1:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    reg_sel = s_sel; reg_wr = s_wr; reg_wdata = s_wd; addr_err = s_ae;
    nmi = s_nmi; soft_rst = s_srst; unit_busy = s_busy; ch_en = s_en; ch_te = s_te;
    it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    s_sel = 0; s_wr = 0; s_ae = 0; s_nmi = 0; s_srst = 0;
  endtask

  task automatic wr(input logic [DW-1:0] d, input logic [OW-1:0] exp, input string tag);
    s_sel = 1; s_wr = 1; s_wd = d;
    tick(exp, tag);
  endtask

  task automatic rd(input logic [OW-1:0] exp, input string tag);
    s_sel = 1; s_wr = 0;
    tick(exp, tag);
  endtask

  initial begin : monitor
    item_t it;
    logic [OW-1:0] got;
    forever begin
      @(posedge clk);
      #5;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        got = {abort_req, ch_permit, rd_data};
        n_run++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : driver
    s_sel = 0; s_wr = 0; s_ae = 0; s_nmi = 0; s_srst = 0; s_busy = 0;
    s_wd = '0; s_en = 4'hF; s_te = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    tick(mk(0, 4'h0, 3'd0), "R1 power-on reset state");
    wr(32'h1, mk(0, 4'hF, 3'd1), "R7 enable permits all");
    s_te = 4'h4; tick(mk(0, 4'hB, 3'd1), "R7 transfer-end blocks ch2");
    s_en = 4'h7; tick(mk(0, 4'h3, 3'd1), "R7 channel enable off ch3");
    s_en = 4'hF; s_te = 4'h0;
    wr(32'hFFFF_FFFE, mk(0, 4'h0, 3'd0), "R2 upper bits and flag ones ignored");
    wr(32'h1, mk(0, 4'hF, 3'd1), "R2 enable rewritten");
    s_busy = 1; s_ae = 1; tick(mk(1, 4'h0, 3'd5), "R3 R9 address error aborts");
    s_busy = 0; tick(mk(0, 4'h0, 3'd5), "R3 flag sticky");
    wr(32'h1, mk(0, 4'h0, 3'd5), "R5 write 0 without read keeps flag");
    rd(mk(0, 4'h0, 3'd5), "R5 read returns flag");
    wr(32'h1, mk(0, 4'hF, 3'd1), "R5 handshake clears flag");
    s_ae = 1; tick(mk(0, 4'h0, 3'd5), "R3 set again idle");
    rd(mk(0, 4'h0, 3'd5), "R5 read");
    s_ae = 1; wr(32'h1, mk(0, 4'h0, 3'd5), "R6 set wins over clear");
    wr(32'h1, mk(0, 4'h0, 3'd5), "R5 record dropped by write");
    rd(mk(0, 4'h0, 3'd5), "R5 read");
    wr(32'h1, mk(0, 4'hF, 3'd1), "R5 clear");
    s_busy = 1; s_nmi = 1; tick(mk(0, 4'hF, 3'd3), "R8 nmi keeps running unit");
    tick(mk(0, 4'hF, 3'd3), "R8 unit still busy");
    s_busy = 0; tick(mk(0, 4'h0, 3'd3), "R8 stop after unit");
    rd(mk(0, 4'h0, 3'd3), "R5 read nmi");
    wr(32'h1, mk(0, 4'hF, 3'd1), "R5 nmi cleared");
    s_nmi = 1; tick(mk(0, 4'h0, 3'd3), "R4 nmi sets while idle");
    rd(mk(0, 4'h0, 3'd3), "R5 read nmi only");
    s_ae = 1; tick(mk(0, 4'h0, 3'd7), "R3 address error");
    wr(32'h1, mk(0, 4'h0, 3'd5), "R5 record is per flag");
    rd(mk(0, 4'h0, 3'd5), "R5 read");
    wr(32'h1, mk(0, 4'hF, 3'd1), "R5 clear ae");
    s_busy = 1; wr(32'h0, mk(1, 4'h0, 3'd0), "R9 enable cleared mid unit");
    s_busy = 0; tick(mk(0, 4'h0, 3'd0), "R9 abort ends when idle");
    wr(32'h1, mk(0, 4'hF, 3'd1), "R7 re-enable");
    s_nmi = 1; tick(mk(0, 4'h0, 3'd3), "R4 nmi");
    s_srst = 1; tick(mk(0, 4'h0, 3'd0), "R1 manual reset");
    wr(32'h1, mk(0, 4'hF, 3'd1), "R1 flags gone after manual reset");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule